// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This block moves data between system memory and a disk drive's data FIFO without processor involvement. Software loads a pointer to a table of descriptors in memory through a small port window, then writes a count to a second port in the same window. That count write starts the engine at once. There is no separate start bit. The transfer direction travels in the two low bits of the table pointer. Each descriptor has two 32-bit words: a buffer address followed by a length in 32-bit words.

Two independent channels are present. The second channel's window is the first one with host address bit 7 inverted. Both channels share one memory port, which uses a request/grant handshake, and channel 0 has priority on it. The engine walks the table and fetches one descriptor word per accepted memory access. It then streams the buffer words to or from the drive side, paced by the drive's DMA request line. When it finishes, the count port reads a fixed completion value and the channel's interrupt status bit rises. An abort input per channel returns the engine to idle without signalling completion.

Top module: `bmdma_top`

## Requirements
- R1: A host write reaches a channel only when `host_addr` with bits 7, 1 and 0 masked equals the window base 0x04 under the same mask. Bit 7 equal to the base selects channel 0, and bit 7 inverted selects channel 1. Any other address changes no register.
- R2: A write at offset 0 stores the 32-bit table pointer, and a read at offset 0 returns it. Pointer bits 1:0 give the direction: 2'b10 means drive to memory, and any other value (nominally 2'b01) means memory to drive. The table starts at the pointer with bits 1:0 cleared.
- R3: A write at offset 2 while the channel is idle starts a transfer. The low 16 bits are loaded as the count with bit 0 forced to 1. A count C moves (C>>1)+1 descriptors. Reading offset 2 returns {16'h0, count}.
- R4: Descriptor k sits at table+8k and holds a buffer address (bits 1:0 ignored). The word at table+8k+4 holds a length: its bits 15:0 give the number of 32-bit words, and its upper bits are ignored. A length of 0 moves no data.
- R5: The count decrements by one on every descriptor word the memory accepts.
- R6: After the last data word of the last descriptor, the count reads 0x00FF and the channel's `bm_irq` bit is 1. The next accepted start clears that bit.
- R7: Memory to drive: buffer words are read at ascending addresses. Each word appears on `drv_wdata` with a one-cycle `drv_wr` pulse, and only in a cycle where `drv_dmarq` is high.
- R8: Drive to memory: `drv_rd` pulses only while `drv_dmarq` is high. The word presented on `drv_rdata` in that cycle is written to the next ascending buffer address.
- R9: A count write while the channel is busy changes nothing.
- R10: `dma_abort` returns the channel to idle with no further memory requests. The count keeps its value and `bm_irq` does not rise. Abort wins over a start or a completion in the same cycle.
- R11: A memory request holds its address, direction and data until `mem_gnt`. When both channels request, channel 0 is served first.
- R12: After reset, both channels are idle, both ports read 0, `bm_irq` is 0 and `mem_req` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 8 | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, combinational from host_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_gnt | input | 1 | Access accepted in a cycle where mem_req is also high |
| mem_rdata | input | 32 | Read data, valid in the grant cycle |
| drv_dmarq | input | 2 | Drive DMA request, one bit per channel |
| drv_wr | output | 2 | Word strobe toward the drive, per channel |
| drv_wdata | output | 64 | Data toward the drive, 32 bits per channel |
| drv_rd | output | 2 | Word taken from the drive, per channel |
| drv_rdata | input | 64 | Data from the drive, 32 bits per channel |
| dma_abort | input | 2 | Abort, per channel |
| bm_irq | output | 2 | Bus-master interrupt status, per channel |

## Verification
Abort and completion can fall in the same cycle. The bench forces both the grant and the drive request high, which makes the timing deterministic. It watches for the strobe of the final word at the drive port and raises abort exactly in the cycle the engine spends finishing. It then checks that `bm_irq` stays low and that the count still reads 0xFFFF rather than 0x00FF.

A second pairing is a count write arriving while a transfer is stalled on the memory grant. The bench checks that the count readback is unchanged. It also checks that a single grant pulse with both channels requesting decrements only channel 0's count.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam int WORD_W = 32;
    localparam int CNT_W  = 16;
    localparam logic [CNT_W-1:0] DONE_MARK = 16'h00FF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC_ADDR,
        ST_DESC_LEN,
        ST_MEM_RD,
        ST_PUSH,
        ST_PULL,
        ST_MEM_WR,
        ST_FINISH
    } eng_state_e;

    typedef struct packed {
        logic              req;
        logic              we;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } mem_cmd_t;

    // Direction code 2'b10 selects drive-to-memory; every other code moves
    // memory-to-drive.
    function automatic logic dir_to_mem(input logic [1:0] code);
        return code == 2'b10;
    endfunction

    // The descriptor count is always odd (two words per descriptor, minus one).
    function automatic logic [CNT_W-1:0] norm_count(input logic [CNT_W-1:0] v);
        return v | {{(CNT_W-1){1'b0}}, 1'b1};
    endfunction

endpackage

// File: rtl/bmdma_arb.sv
module bmdma_arb
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  mem_cmd_t          cmd_in [NUM_CH],
    input  logic              mem_gnt,
    output mem_cmd_t          cmd_out,
    output logic [NUM_CH-1:0] gnt_out
);

    logic [NUM_CH-1:0] req_vec;
    logic              found;

    always_comb begin
        cmd_out = '0;
        gnt_out = '0;
        found   = 1'b0;
        for (int i = 0; i < NUM_CH; i++) begin
            req_vec[i] = cmd_in[i].req;
            if (cmd_in[i].req && !found) begin
                found      = 1'b1;
                cmd_out    = cmd_in[i];
                gnt_out[i] = mem_gnt;
            end
        end
    end

    assert_grant_onehot_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_out));

    assert_low_index_first_R11: assert property (@(posedge clk) disable iff (rst)
        (req_vec[0] && mem_gnt) |-> (gnt_out[0] && $countones(gnt_out) == 1));

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr_tbl,
    input  logic              cfg_wr_cnt,
    input  logic [WORD_W-1:0] cfg_wdata,
    output logic [WORD_W-1:0] tbl_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              irq,
    input  logic              abort,
    output mem_cmd_t          cmd,
    input  logic              mem_gnt,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              drv_dmarq,
    output logic              drv_wr,
    output logic [WORD_W-1:0] drv_wdata,
    output logic              drv_rd,
    input  logic [WORD_W-1:0] drv_rdata
);

    localparam int PTR_W = WORD_W - 2;

    eng_state_e        st;
    logic [WORD_W-1:0] tbl_r;
    logic [CNT_W-1:0]  cnt_r;
    logic [PTR_W-1:0]  dptr;
    logic [PTR_W-1:0]  bptr;
    logic [LEN_W-1:0]  len_r;
    logic [WORD_W-1:0] hold_r;
    logic              last_r;
    logic              irq_r;

    logic       accept;
    logic       is_desc;
    logic       last_now;
    logic       to_mem;
    eng_state_e after_desc;
    eng_state_e after_len;

    always_comb begin
        is_desc   = (st == ST_DESC_ADDR) || (st == ST_DESC_LEN);
        cmd.req   = is_desc || (st == ST_MEM_RD) || (st == ST_MEM_WR);
        cmd.we    = (st == ST_MEM_WR);
        cmd.addr  = is_desc ? {dptr, 2'b00} : {bptr, 2'b00};
        cmd.wdata = hold_r;
        accept    = cmd.req && mem_gnt;
        to_mem    = dir_to_mem(tbl_r[1:0]);
        last_now  = (cnt_r == '0);
        after_desc = last_r ? ST_FINISH : ST_DESC_ADDR;
        if (mem_rdata[LEN_W-1:0] == '0)
            after_len = last_now ? ST_FINISH : ST_DESC_ADDR;
        else
            after_len = to_mem ? ST_PULL : ST_MEM_RD;
        drv_wr    = (st == ST_PUSH) && drv_dmarq;
        drv_rd    = (st == ST_PULL) && drv_dmarq;
        drv_wdata = hold_r;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            tbl_r  <= '0;
            cnt_r  <= '0;
            dptr   <= '0;
            bptr   <= '0;
            len_r  <= '0;
            hold_r <= '0;
            last_r <= 1'b0;
            irq_r  <= 1'b0;
        end else begin
            if (cfg_wr_tbl) tbl_r <= cfg_wdata;
            if (abort) begin
                st <= ST_IDLE;
            end else begin
                unique case (st)
                    ST_IDLE: if (cfg_wr_cnt) begin
                        cnt_r <= norm_count(cfg_wdata[CNT_W-1:0]);
                        dptr  <= tbl_r[WORD_W-1:2];
                        irq_r <= 1'b0;
                        st    <= ST_DESC_ADDR;
                    end
                    ST_DESC_ADDR: if (accept) begin
                        bptr  <= mem_rdata[WORD_W-1:2];
                        dptr  <= dptr + 1'b1;
                        cnt_r <= cnt_r - 1'b1;
                        st    <= ST_DESC_LEN;
                    end
                    ST_DESC_LEN: if (accept) begin
                        len_r  <= mem_rdata[LEN_W-1:0];
                        dptr   <= dptr + 1'b1;
                        cnt_r  <= cnt_r - 1'b1;
                        last_r <= last_now;
                        st     <= after_len;
                    end
                    ST_MEM_RD: if (accept) begin
                        hold_r <= mem_rdata;
                        bptr   <= bptr + 1'b1;
                        len_r  <= len_r - 1'b1;
                        st     <= ST_PUSH;
                    end
                    ST_PUSH: if (drv_dmarq) begin
                        st <= (len_r == '0) ? after_desc : ST_MEM_RD;
                    end
                    ST_PULL: if (drv_dmarq) begin
                        hold_r <= drv_rdata;
                        st     <= ST_MEM_WR;
                    end
                    ST_MEM_WR: if (accept) begin
                        bptr  <= bptr + 1'b1;
                        len_r <= len_r - 1'b1;
                        st    <= (len_r == LEN_W'(1)) ? after_desc : ST_PULL;
                    end
                    ST_FINISH: begin
                        cnt_r <= DONE_MARK;
                        irq_r <= 1'b1;
                        st    <= ST_IDLE;
                    end
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign tbl_q = tbl_r;
    assign cnt_q = cnt_r;
    assign irq   = irq_r;

    assert_req_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd.req && !mem_gnt && !abort) |=> (cmd.req && $stable(cmd.addr) && $stable(cmd.we)));

    assert_done_mark_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_r) |-> (cnt_r == DONE_MARK));

    assert_abort_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!cmd.req && !$rose(irq_r) && $stable(cnt_r)));

    assert_busy_count_R9: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr_cnt && st != ST_IDLE && st != ST_FINISH && !accept) |=> $stable(cnt_r));

    assert_push_data_R7: assert property (@(posedge clk) disable iff (rst)
        (st == ST_MEM_RD && accept && !abort) |=> (drv_wdata == $past(mem_rdata)));

    assert_pull_write_R8: assert property (@(posedge clk) disable iff (rst)
        (drv_rd && !abort) |=> (cmd.req && cmd.we && cmd.wdata == $past(drv_rdata)));

endmodule

// File: rtl/bmdma_top.sv
module bmdma_top
    import bmdma_pkg::*;
#(
    parameter int               ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] WIN_BASE = 8'h04,
    parameter int               CH_BIT   = 7,
    parameter int               LEN_W    = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [WORD_W-1:0]   host_wdata,
    output logic [WORD_W-1:0]   host_rdata,
    output logic                mem_req,
    output logic                mem_we,
    output logic [WORD_W-1:0]   mem_addr,
    output logic [WORD_W-1:0]   mem_wdata,
    input  logic                mem_gnt,
    input  logic [WORD_W-1:0]   mem_rdata,
    input  logic [1:0]          drv_dmarq,
    output logic [1:0]          drv_wr,
    output logic [2*WORD_W-1:0] drv_wdata,
    output logic [1:0]          drv_rd,
    input  logic [2*WORD_W-1:0] drv_rdata,
    input  logic [1:0]          dma_abort,
    output logic [1:0]          bm_irq
);

    localparam int NUM_CH = 2;
    localparam logic [ADDR_W-1:0] MATCH_MASK =
        ~((ADDR_W'(1) << CH_BIT) | ADDR_W'(3));

    logic             win_hit;
    logic             win_ch;
    logic [1:0]       win_off;
    logic [WORD_W-1:0] tbl_q [NUM_CH];
    logic [CNT_W-1:0]  cnt_q [NUM_CH];
    mem_cmd_t          ch_cmd [NUM_CH];
    mem_cmd_t          arb_cmd;
    logic [NUM_CH-1:0] ch_gnt;

    always_comb begin
        win_hit = ((host_addr ^ WIN_BASE) & MATCH_MASK) == '0;
        win_ch  = host_addr[CH_BIT] ^ WIN_BASE[CH_BIT];
        win_off = host_addr[1:0];
        host_rdata = '0;
        if (win_hit) begin
            if (win_off == 2'd0)      host_rdata = tbl_q[win_ch];
            else if (win_off == 2'd2) host_rdata = {{(WORD_W-CNT_W){1'b0}}, cnt_q[win_ch]};
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic sel;
        assign sel = host_wr && win_hit && (win_ch == 1'(g));
        bmdma_chan #(.LEN_W(LEN_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg_wr_tbl (sel && win_off == 2'd0),
            .cfg_wr_cnt (sel && win_off == 2'd2),
            .cfg_wdata  (host_wdata),
            .tbl_q      (tbl_q[g]),
            .cnt_q      (cnt_q[g]),
            .irq        (bm_irq[g]),
            .abort      (dma_abort[g]),
            .cmd        (ch_cmd[g]),
            .mem_gnt    (ch_gnt[g]),
            .mem_rdata  (mem_rdata),
            .drv_dmarq  (drv_dmarq[g]),
            .drv_wr     (drv_wr[g]),
            .drv_wdata  (drv_wdata[g*WORD_W +: WORD_W]),
            .drv_rd     (drv_rd[g]),
            .drv_rdata  (drv_rdata[g*WORD_W +: WORD_W])
        );
    end

    bmdma_arb #(.NUM_CH(NUM_CH)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .cmd_in  (ch_cmd),
        .mem_gnt (mem_gnt),
        .cmd_out (arb_cmd),
        .gnt_out (ch_gnt)
    );

    assign mem_req   = arb_cmd.req;
    assign mem_we    = arb_cmd.we;
    assign mem_addr  = arb_cmd.addr;
    assign mem_wdata = arb_cmd.wdata;

    assert_outside_window_R1: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !win_hit) |=> ($stable(tbl_q[0]) && $stable(tbl_q[1])));

endmodule

// File: tb/bmdma_top_tb.sv
module bmdma_top_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        mem_req, mem_we, mem_gnt;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;
    logic [1:0]  drv_dmarq, drv_wr, drv_rd, bm_irq;
    logic [1:0]  dma_abort = '0;
    logic [63:0] drv_wdata, drv_rdata;

    int total = 0;
    int bad = 0;
    int gnt_mode = 0;
    int rq_mode = 1;

    logic [31:0] mem [1024];
    logic [31:0] rx [2][256];
    int rx_n [2];
    int tx_n [2];
    int dlen [2][4];
    int dbuf [2][4];
    int nd [2];
    int rx_base [2];
    int tx_base [2];

    always #2 clk = ~clk;

    bmdma_top u_dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_gnt(mem_gnt), .mem_rdata(mem_rdata), .drv_dmarq(drv_dmarq),
        .drv_wr(drv_wr), .drv_wdata(drv_wdata), .drv_rd(drv_rd),
        .drv_rdata(drv_rdata), .dma_abort(dma_abort), .bm_irq(bm_irq)
    );

    function automatic logic [31:0] pat(input int c, input int i);
        return 32'hA500_0000 ^ (32'(c) << 20) ^ (32'(i) * 32'h0001_0203);
    endfunction

    function automatic logic [7:0] win(input int c, input int off);
        return (8'h04 | 8'(off)) ^ (c != 0 ? 8'h80 : 8'h00);
    endfunction

    assign mem_rdata = mem[mem_addr[11:2]];
    assign drv_rdata = {pat(1, tx_n[1]), pat(0, tx_n[0])};

    always @(posedge clk) begin
        if (mem_req && mem_gnt && mem_we) mem[mem_addr[11:2]] <= mem_wdata;
        for (int c = 0; c < 2; c++) begin
            if (drv_wr[c]) begin
                rx[c][rx_n[c] % 256] <= drv_wdata[c*32 +: 32];
                rx_n[c] <= rx_n[c] + 1;
            end
            if (drv_rd[c]) tx_n[c] <= tx_n[c] + 1;
        end
    end

    always @(negedge clk) begin
        mem_gnt <= (gnt_mode == 2) || (gnt_mode == 1 && ($urandom % 4) != 0);
        for (int c = 0; c < 2; c++)
            drv_dmarq[c] <= (rq_mode == 2) || (rq_mode == 1 && ($urandom % 3) != 0);
    end

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
        end
    endtask

    task automatic hwr(input logic [7:0] a, input logic [31:0] d);
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
    endtask

    task automatic hrd(input logic [7:0] a, output logic [31:0] d);
        host_addr = a; #1; d = host_rdata;
    endtask

    // Table for channel c at word 64+64c, buffers at word 256+256c+16k.
    task automatic setup(input int c, input int n, input int lmax);
        int tw;
        tw = 64 + 64 * c;
        nd[c] = n;
        for (int k = 0; k < n; k++) begin
            dlen[c][k] = (lmax == 0) ? 0 : int'($urandom % (lmax + 1));
            dbuf[c][k] = 256 + 256 * c + 16 * k;
            mem[tw + 2*k]     = {20'h0, 10'(dbuf[c][k]), 2'($urandom)};
            mem[tw + 2*k + 1] = {16'($urandom), 16'(dlen[c][k])};
            for (int i = 0; i < 16; i++) mem[dbuf[c][k] + i] = $urandom;
        end
    endtask

    task automatic start(input int c, input int dir);
        logic [31:0] r;
        rx_base[c] = rx_n[c];
        tx_base[c] = tx_n[c];
        hwr(win(c, 0), {20'h0, 10'(64 + 64 * c), 2'(dir)});
        hwr(win(c, 2), 32'(2 * nd[c] - 1));
        hrd(win(c, 2), r);
        check("R6 irq cleared by start", 32'(bm_irq[c]), 32'd0);
    endtask

    task automatic finish(input int c, input int dir);
        logic [31:0] r;
        int w;
        int k2;
        k2 = 0;
        while (!bm_irq[c] && k2 < 4000) begin step(); k2++; end
        check("R6 irq set on completion", 32'(bm_irq[c]), 32'd1);
        hrd(win(c, 2), r);
        check("R6 count reads 0x00FF", r, 32'h0000_00FF);
        w = 0;
        for (int k = 0; k < nd[c]; k++)
            for (int i = 0; i < dlen[c][k]; i++) begin
                if (dir == 2)
                    check("R8 drive word in memory", mem[dbuf[c][k] + i], pat(c, tx_base[c] + w));
                else
                    check("R7 memory word at drive", rx[c][(rx_base[c] + w) % 256], mem[dbuf[c][k] + i]);
                w++;
            end
        if (dir == 2) check("R8 drive word count", 32'(tx_n[c] - tx_base[c]), 32'(w));
        else          check("R7 drive word count", 32'(rx_n[c] - rx_base[c]), 32'(w));
    endtask

    initial begin
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int c, dir, k2;
        void'($urandom(32'd7177));
        rx_n[0] = 0; rx_n[1] = 0; tx_n[0] = 0; tx_n[1] = 0;
        for (int i = 0; i < 1024; i++) mem[i] = $urandom;
        repeat (4) step();
        rst = 1'b0;

        // R12 reset state
        for (int cc = 0; cc < 2; cc++) begin
            hrd(win(cc, 0), r); check("R12 table reset", r, 32'h0);
            hrd(win(cc, 2), r); check("R12 count reset", r, 32'h0);
        end
        check("R12 irq reset", 32'(bm_irq), 32'h0);
        check("R12 no request", 32'(mem_req), 32'h0);

        // R1/R2 decode and readback
        hwr(win(0, 0), 32'h1234_5679);
        hwr(win(1, 0), 32'hCAFE_0002);
        hrd(win(0, 0), r); check("R2 table readback ch0", r, 32'h1234_5679);
        hrd(win(1, 0), r); check("R1 bit7 selects ch1", r, 32'hCAFE_0002);
        hwr(8'h14, 32'hFFFF_FFFF);
        hwr(8'h05, 32'h0000_0000);
        hrd(win(0, 0), r); check("R1 outside write ignored ch0", r, 32'h1234_5679);
        hrd(win(1, 0), r); check("R1 outside write ignored ch1", r, 32'hCAFE_0002);
        hrd(8'h14, r); check("R1 outside read is zero", r, 32'h0);

        // R3/R5/R9/R11 stalled-grant sequence
        gnt_mode = 0; rq_mode = 1;
        setup(0, 2, 5);
        setup(1, 1, 5);
        rx_base[0] = rx_n[0]; tx_base[1] = tx_n[1];
        hwr(win(0, 0), {20'h0, 10'(64), 2'd1});
        hwr(win(0, 2), 32'h0000_0002);
        hrd(win(0, 2), r); check("R3 count bit0 forced", r, 32'h3);
        hwr(win(0, 2), 32'h0000_0007);
        hrd(win(0, 2), r); check("R9 busy count write ignored", r, 32'h3);
        hwr(win(1, 0), {20'h0, 10'(128), 2'd2});
        hwr(win(1, 2), 32'h0000_0001);
        check("R11 request while waiting", 32'(mem_req), 32'h1);
        gnt_mode = 2; step(); gnt_mode = 0; step(); step();
        hrd(win(0, 2), r); check("R5 decrement on accept", r, 32'h2);
        hrd(win(1, 2), r); check("R11 ch1 waits behind ch0", r, 32'h1);
        gnt_mode = 1;
        finish(0, 1);
        finish(1, 2);

        // R4 zero-length descriptors move nothing
        setup(1, 3, 0);
        start(1, 1);
        finish(1, 1);

        // R10 abort mid-transfer
        setup(1, 3, 6);
        dlen[1][0] = 6; mem[128 + 1] = {16'h0, 16'd6};
        start(1, 2);
        repeat (12) step();
        dma_abort[1] = 1'b1; step(); dma_abort[1] = 1'b0;
        hrd(win(1, 2), r);
        repeat (20) step();
        check("R10 no irq after abort", 32'(bm_irq[1]), 32'h0);
        check("R10 no request after abort", 32'(mem_req), 32'h0);
        begin
            logic [31:0] r2;
            hrd(win(1, 2), r2);
            check("R10 count retained", r2, r);
        end

        // R10 abort coincident with completion
        gnt_mode = 2; rq_mode = 2;
        setup(0, 1, 0);
        dlen[0][0] = 2; mem[64 + 1] = {16'h0, 16'd2};
        start(0, 1);
        k2 = 0;
        while (!(drv_wr[0] && (rx_n[0] - rx_base[0]) == 1) && k2 < 200) begin step(); k2++; end
        step();
        dma_abort[0] = 1'b1; step(); dma_abort[0] = 1'b0;
        check("R10 abort beats completion irq", 32'(bm_irq[0]), 32'h0);
        hrd(win(0, 2), r); check("R10 abort beats completion count", r, 32'h0000_FFFF);

        // random transfers, single channel and both together
        gnt_mode = 1; rq_mode = 1;
        for (int it = 0; it < 10; it++) begin
            c = int'($urandom % 2);
            dir = ($urandom % 2 != 0) ? 2 : 1;
            setup(c, 1 + int'($urandom % 4), 8);
            start(c, dir);
            finish(c, dir);
        end
        for (int it = 0; it < 4; it++) begin
            int d0, d1;
            d0 = ($urandom % 2 != 0) ? 2 : 1;
            d1 = ($urandom % 2 != 0) ? 2 : 1;
            setup(0, 1 + int'($urandom % 4), 8);
            setup(1, 1 + int'($urandom % 4), 8);
            start(0, d0);
            start(1, d1);
            finish(0, d0);
            finish(1, d1);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule